// File: doc/BRIEF.md
# Two-Level Energy Accumulation Timer

This block integrates a stream of signed per-sample energy products over a programmable window built from two nested counts. An inner stage adds a selectable number of consecutive valid samples. Each time the inner count is reached, the inner partial sum is folded into an outer stage. When the outer stage has taken the programmed number of inner results, the window is complete. The total of every sample in the window is then latched into a result register and both stages are cleared. A one-cycle done pulse and a sticky interrupt flag announce the new result.

With a sample rate of about 2520.6 per second, the window lasts (inner count x outer count) / 2520.6 seconds. The running inner and outer counters are brought out so that the surrounding logic can see how far the current window has progressed. Cycles with the valid strobe low have no effect on the accumulation.

Top module: `energyAccumTimer`

## Requirements
- R1: After reset, the result, both counters, the done pulse and the sticky flag are all zero.
- R2: The inner count is chosen by the 2-bit preSel field as 0 -> 42, 1 -> 50, 2 -> 84 and 3 -> 100 samples. The innerCount output steps by one per valid sample and returns to zero on the sample that reaches the selected count, and on that sample outerCount steps by one.
- R3: The window holds cycleCount inner results. A cycleCount of 0 behaves as 1.
- R4: On completion, result holds the exact signed sum of every valid sample in the window, as a 45-bit two's complement value, starting in the cycle after the completing sample's clock edge.
- R5: donePulse is high for exactly one cycle: the cycle after the edge that took the window's last sample.
- R6: irqFlag goes to 1 together with donePulse and stays set until a cycle with irqClear = 1. If a completion and a clear fall on the same edge, the flag stays set.
- R7: After completion, both counters are zero and the next window accumulates from a zero sum.
- R8: A cycle with sampleValid = 0 changes neither counter nor any partial sum.
- R9: result keeps its value between completions.
- R10: A full window of 100 x 63 samples all at the most negative or the most positive 32-bit value gives the exact sum with no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | Strobe: sampleData carries a sample this cycle |
| sampleData | input | 32 | Signed energy product |
| preSel | input | 2 | Inner sample count select |
| cycleCount | input | 6 | Number of inner results per window (0 means 1) |
| irqClear | input | 1 | Write-one clear of the sticky flag |
| result | output | 45 | Latched signed window total |
| donePulse | output | 1 | One-cycle completion pulse |
| irqFlag | output | 1 | Sticky completion flag |
| innerCount | output | 7 | Samples taken in the current inner group |
| outerCount | output | 6 | Inner groups finished in the current window |

## Verification
The assertions assume that preSel and cycleCount hold still while a window is in progress. They also assume that completions are separated by at least one idle or sample cycle, which follows from the minimum window of 42 samples. The bench changes both settings only at reset or in the cycle right after a completion, when both counters are zero. Random sample values, random gaps without a strobe and random clear writes are mixed freely. Directed windows cover the cycleCount = 0 case and full 6300-sample windows at both extremes of the sample range.

// File: rtl/energy_accum_pkg.sv
package energy_accum_pkg;

  typedef struct packed {
    logic addSample;   // take the current sample
    logic innerRoll;   // inner group finishes with this sample
    logic windowDone;  // whole window finishes with this sample
  } accStrobe_t;

endpackage

// File: rtl/energy_accum_ctrl.sv
module energy_accum_ctrl
  import energy_accum_pkg::*;
#(
  parameter int CYCLE_W = 6,
  parameter int CNT_W   = 7,
  parameter int PRE_C0  = 42,
  parameter int PRE_C1  = 50,
  parameter int PRE_C2  = 84,
  parameter int PRE_C3  = 100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic [1:0]         preSel,
  input  logic [CYCLE_W-1:0] cycleCount,
  input  logic               irqClear,
  output accStrobe_t         strb,
  output logic               donePulse,
  output logic               irqFlag,
  output logic [CNT_W-1:0]   innerCnt,
  output logic [CYCLE_W-1:0] outerCnt
);

  logic [CNT_W-1:0]   preTarget;
  logic [CYCLE_W-1:0] cycTarget;

  always_comb begin
    unique case (preSel)
      2'd0:    preTarget = CNT_W'(PRE_C0);
      2'd1:    preTarget = CNT_W'(PRE_C1);
      2'd2:    preTarget = CNT_W'(PRE_C2);
      default: preTarget = CNT_W'(PRE_C3);
    endcase
  end

  assign cycTarget = (cycleCount == '0) ? CYCLE_W'(1) : cycleCount;

  always_comb begin
    strb.addSample  = sampleValid;
    strb.innerRoll  = sampleValid && (innerCnt >= preTarget - CNT_W'(1));
    strb.windowDone = strb.innerRoll && (outerCnt >= cycTarget - CYCLE_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      innerCnt <= '0;
      outerCnt <= '0;
    end else if (strb.addSample) begin
      if (strb.innerRoll) begin
        innerCnt <= '0;
        outerCnt <= strb.windowDone ? '0 : outerCnt + CYCLE_W'(1);
      end else begin
        innerCnt <= innerCnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      donePulse <= 1'b0;
      irqFlag   <= 1'b0;
    end else begin
      donePulse <= strb.windowDone;
      if (strb.windowDone)
        irqFlag <= 1'b1;
      else if (irqClear)
        irqFlag <= 1'b0;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R5

  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> irqFlag); // R6

  AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (innerCnt == '0 && outerCnt == '0)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> ($stable(innerCnt) && $stable(outerCnt))); // R8

  AST_INNER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    innerCnt < preTarget); // R2

endmodule

// File: rtl/energy_accum_dpath.sv
module energy_accum_dpath
  import energy_accum_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int ACC_W    = 45
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  accStrobe_t                 strb,
  input  logic signed [SAMPLE_W-1:0] sampleData,
  output logic signed [ACC_W-1:0]    resultQ
);

  localparam int EXT_W = ACC_W - SAMPLE_W;

  logic signed [ACC_W-1:0] sampleExt;
  logic signed [ACC_W-1:0] innerSum;
  logic signed [ACC_W-1:0] outerSum;
  logic signed [ACC_W-1:0] innerNext;
  logic signed [ACC_W-1:0] windowTotal;

  assign sampleExt   = {{EXT_W{sampleData[SAMPLE_W-1]}}, sampleData};
  assign innerNext   = innerSum + sampleExt;
  assign windowTotal = outerSum + innerNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      innerSum <= '0;
      outerSum <= '0;
    end else if (strb.addSample) begin
      innerSum <= strb.innerRoll ? '0 : innerNext;
      if (strb.windowDone)
        outerSum <= '0;
      else if (strb.innerRoll)
        outerSum <= windowTotal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      resultQ <= '0;
    else if (strb.windowDone)
      resultQ <= windowTotal;
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.windowDone |=> $stable(resultQ)); // R9

  AST_IDLE_SUMS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.addSample |=> ($stable(innerSum) && $stable(outerSum))); // R8

endmodule

// File: rtl/energyAccumTimer.sv
module energyAccumTimer
  import energy_accum_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int CYCLE_W  = 6,
  parameter int ACC_W    = 45,
  parameter int CNT_W    = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleData,
  input  logic [1:0]                 preSel,
  input  logic [CYCLE_W-1:0]         cycleCount,
  input  logic                       irqClear,
  output logic signed [ACC_W-1:0]    result,
  output logic                       donePulse,
  output logic                       irqFlag,
  output logic [CNT_W-1:0]           innerCount,
  output logic [CYCLE_W-1:0]         outerCount
);

  accStrobe_t strb;

  energy_accum_ctrl #(
    .CYCLE_W (CYCLE_W),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .preSel      (preSel),
    .cycleCount  (cycleCount),
    .irqClear    (irqClear),
    .strb        (strb),
    .donePulse   (donePulse),
    .irqFlag     (irqFlag),
    .innerCnt    (innerCount),
    .outerCnt    (outerCount)
  );

  energy_accum_dpath #(
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .sampleData (sampleData),
    .resultQ    (result)
  );

endmodule

// File: tb/energyAccumTimer_tb.sv
module energyAccumTimer_tb;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               sampleValid = 1'b0;
  logic signed [31:0] sampleData = '0;
  logic [1:0]         preSel = '0;
  logic [5:0]         cycleCount = '0;
  logic               irqClear = 1'b0;
  logic signed [44:0] result;
  logic               donePulse;
  logic               irqFlag;
  logic [6:0]         innerCount;
  logic [5:0]         outerCount;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // reference model state
  int                 mInner = 0;
  int                 mOuter = 0;
  logic signed [44:0] mSum = '0;
  logic signed [44:0] mResult = '0;
  logic               mDone = 1'b0;
  logic               mFlag = 1'b0;
  int                 doneCount = 0;

  always #2 clk = ~clk;

  energyAccumTimer u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .sampleData  (sampleData),
    .preSel      (preSel),
    .cycleCount  (cycleCount),
    .irqClear    (irqClear),
    .result      (result),
    .donePulse   (donePulse),
    .irqFlag     (irqFlag),
    .innerCount  (innerCount),
    .outerCount  (outerCount)
  );

  function automatic int preCountOf(input logic [1:0] sel);
    case (sel)
      2'd0: return 42;
      2'd1: return 50;
      2'd2: return 84;
      default: return 100;
    endcase
  endfunction

  function automatic int cycCountOf(input logic [5:0] c);
    return (c == 0) ? 1 : int'(c);
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // drive at negedge, let one rising edge pass, compare at next negedge
  task automatic step(input logic v, input logic [31:0] d, input logic c, input string resTag);
    sampleValid = v;
    sampleData  = d;
    irqClear    = c;
    @(posedge clk);
    mDone = 1'b0;
    if (v) begin
      mSum += {{13{d[31]}}, d};
      mInner++;
      if (mInner >= preCountOf(preSel)) begin
        mInner = 0;
        mOuter++;
        if (mOuter >= cycCountOf(cycleCount)) begin
          mOuter  = 0;
          mResult = mSum;
          mSum    = '0;
          mDone   = 1'b1;
          doneCount++;
        end
      end
    end
    if (mDone) mFlag = 1'b1;
    else if (c) mFlag = 1'b0;
    @(negedge clk);
    check(v ? "R2" : "R8", "innerCount", innerCount, mInner);
    check(mDone ? "R7" : (v ? "R3" : "R8"), "outerCount", outerCount, mOuter);
    check("R5", "donePulse", donePulse, mDone);
    check("R6", "irqFlag", irqFlag, mFlag);
    check(mDone ? resTag : "R9", "result", result, mResult);
  endtask

  task automatic runWindow(input logic [1:0] ps, input logic [5:0] cc, input int mode, input string resTag);
    int target;
    int startDone;
    preSel     = ps;
    cycleCount = cc;
    target     = preCountOf(ps) * cycCountOf(cc);
    startDone  = doneCount;
    for (int i = 0; i < target; i++) begin
      logic [31:0] d;
      case (mode)
        1: d = 32'h8000_0000;
        2: d = 32'h7FFF_FFFF;
        default: d = $urandom;
      endcase
      if (mode == 0) begin
        while (($urandom % 4) == 0)
          step(1'b0, $urandom, ($urandom % 3) == 0, resTag);
      end
      step(1'b1, d, (mode == 0) && (($urandom % 5) == 0), resTag);
    end
    check(resTag, "window completions", doneCount - startDone, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "result", result, 0);
    check("R1", "donePulse", donePulse, 0);
    check("R1", "irqFlag", irqFlag, 0);
    check("R1", "innerCount", innerCount, 0);
    check("R1", "outerCount", outerCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "innerCount after release", innerCount, 0);

    // R8: idle cycles with changing data do nothing
    for (int i = 0; i < 5; i++) step(1'b0, $urandom, 1'b0, "R8");

    // R3: cycle field zero behaves as one inner group
    runWindow(2'd0, 6'd0, 0, "R3");
    // R6: clear then completion with simultaneous clear keeps flag set
    step(1'b0, '0, 1'b1, "R9");
    check("R6", "flag cleared", irqFlag, 0);
    runWindow(2'd1, 6'd1, 0, "R4");
    step(1'b0, '0, 1'b0, "R9");

    // R2/R4/R7: random windows across all presample selects
    for (int w = 0; w < 24; w++)
      runWindow(2'($urandom % 4), 6'($urandom % 4), 0, "R4");
    for (int s = 0; s < 4; s++)
      runWindow(2'(s), 6'd2, 0, "R2");

    // R10: extreme full windows
    runWindow(2'd3, 6'd63, 1, "R10");
    check("R10", "most negative total", result, -45'sd6300 * 45'sd2147483648);
    runWindow(2'd3, 6'd63, 2, "R10");
    check("R10", "most positive total", result, 45'sd6300 * 45'sd2147483647);

    // R9: result holds through idle cycles
    for (int i = 0; i < 4; i++) step(1'b0, $urandom, 1'b1, "R9");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule